// File: doc/BRIEF.md
# I2C Single-Master Transaction Controller

This block is the only master on a two-wire I2C bus and runs one whole transaction for each go strobe. It opens the transaction with a START condition. It then clocks out a 7-bit target address and a direction bit, and after that it moves a programmed number of data bytes. In write mode it transmits the bytes. In read mode it receives them. The transaction ends with a STOP condition.

Both bus lines are open-drain. The block never drives a line high. It only asserts a pull-low enable for SCL and for SDA, and it reads SDA back through the `sda_i` pin. A released line reads high through the external pull-up. The SCL pin has no read-back because the block does not support clock stretching.

The user starts a transfer with one `go_i` pulse and holds the address, direction, byte count and quarter-bit divider on their inputs for that pulse. During a write, `wreq_o` pulses each time a byte is taken from `wdata_i`, and the user then presents the next byte. During a read, each received byte appears on `rdata_o` together with a one-cycle `rvalid_o` pulse. The end of every transaction is marked by a `done_o` pulse. The error flags and the failing byte index stay valid until the next start.

Top module: `i2c_master_ctrl`

## Requirements
- R1: After reset, and whenever no transfer is running, `busy_o`, `scl_oe_o`, `sda_oe_o`, `done_o`, `wreq_o` and `rvalid_o` are all low, so both lines are released.
- R2: On a `go_i` accepted in idle, the block keeps both lines released for two quarter-bit periods. It then pulls SDA low for two more quarters while SCL stays released, which forms the START. Only after that does it pull SCL low.
- R3: Outside START and STOP, `sda_oe_o` changes only while `scl_oe_o` is high, and it never changes in the same cycle as `scl_oe_o`.
- R4: Clocks 1 to 8 after START carry `addr_i` most significant bit first, followed by the direction bit, where `rd_i`=1 means read and 0 means write. A bus bit value of 0 is sent as `sda_oe_o`=1.
- R5: One quarter-bit lasts `div_i`+1 clock cycles, and each bit takes four quarters. SCL is pulled low for the first two quarters and released for the last two. SDA takes its new value at the start of the second quarter. The block samples `sda_i` on the last cycle of the third quarter.
- R6: In a write, the block sends `len_i` bytes from `wdata_i`, each most significant bit first. `wreq_o` pulses in the first cycle of each data byte, which means that byte has been taken. During every ninth clock the block releases SDA, and a low `sda_i` counts as the target's acknowledge.
- R7: In a read, the block releases SDA during the eight data clocks and shifts `sda_i` in most significant bit first. On the ninth clock it pulls SDA low for every byte except the last, which it leaves released (NACK). `rdata_o` and a one-cycle `rvalid_o` appear in the cycle after that ninth clock ends.
- R8: If `sda_i` is high at the address acknowledge, the block sets `addr_nack_o`, goes straight to STOP and clocks no data. No `wreq_o` or `rvalid_o` pulse occurs.
- R9: If a written byte is not acknowledged, the block sets `data_nack_o`, puts that byte's zero-based index on `nack_idx_o` and goes straight to STOP. All error flags clear on the next accepted `go_i`.
- R10: STOP uses four quarters. SCL is low with SDA unchanged, then SCL is low with SDA pulled low, then SCL is released for two quarters, and then SDA is released. `busy_o` falls in the cycle after the last STOP quarter, and `done_o` is high for exactly that one cycle.
- R11: With `len_i`=0, the transfer is the address byte and its acknowledge, followed directly by STOP.
- R12: A `go_i` that arrives while `busy_o` is high is ignored. The running transfer keeps its address, direction and byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Quarter-bit length minus one, in clock cycles; captured at start |
| go_i | input | 1 | Start strobe, accepted only while idle |
| addr_i | input | 7 | Target address |
| rd_i | input | 1 | Direction: 1 read, 0 write |
| len_i | input | CNT_W | Number of data bytes |
| wdata_i | input | 8 | Next byte to write |
| wreq_o | output | 1 | Pulse: current write byte taken, present the next one |
| rdata_o | output | 8 | Last received byte |
| rvalid_o | output | 1 | Pulse: `rdata_o` holds a new byte |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Pulse when a transfer ends |
| addr_nack_o | output | 1 | Address was not acknowledged |
| data_nack_o | output | 1 | A written byte was not acknowledged |
| nack_idx_o | output | CNT_W | Index of the unacknowledged written byte |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The acknowledge decision and the next segment are both settled at the same clock edge that closes a ninth clock. At that edge the block may load the next write byte and pulse `wreq_o`, it may hand over a read byte with `rvalid_o`, or it may abort to STOP when the acknowledge is missing. The bench provokes each of these outcomes with a behavioural target that acknowledges or withholds the acknowledge at chosen bytes. It compares the pin enables and the strobes against an independently built per-cycle expectation, so a strobe one cycle early or late, or an abort that comes one bit too late, shows up as a mismatch. A `go_i` pulse sent in the middle of a transfer checks that the running transfer ignores new start requests.

// File: rtl/i2c_mst_pkg.sv
package i2c_mst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP
  } state_e;

  typedef enum logic [1:0] {
    SEG_ADDR,
    SEG_WR,
    SEG_RD
  } seg_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned BITCNT_W = 4;
  localparam logic [BITCNT_W-1:0] ACK_SLOT = BITCNT_W'(BYTE_W);
endpackage

// File: rtl/i2c_qtr_tick.sv
module i2c_qtr_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [1:0]       phase_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [1:0]       ph_q;

  assign tick_o  = en_i && (cnt_q == div_i);
  assign phase_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
      ph_q  <= ph_q + 2'd1;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  // quarter periods longer than one cycle never tick back to back
  p_tick_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (div_i != '0)) |=> !tick_o);
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  assign q_o = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (load_i)  q_q <= load_val_i;
    else if (shift_i) q_q <= {q_q[W-2:0], bit_i};
  end

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_o == $past(load_val_i)));
endmodule

// File: rtl/i2c_master_ctrl.sv
module i2c_master_ctrl
  import i2c_mst_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             go_i,
  input  logic [6:0]       addr_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [7:0]       wdata_i,
  output logic             wreq_o,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             addr_nack_o,
  output logic             data_nack_o,
  output logic [CNT_W-1:0] nack_idx_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  input  logic             sda_i
);
  state_e              state_q;
  seg_e                seg_q;
  logic [BITCNT_W-1:0] bit_cnt_q;
  logic [CNT_W-1:0]    byte_idx_q, len_q;
  logic [DIV_W-1:0]    div_q;
  logic                rd_q, ack_q, sda_oe_q;
  logic [7:0]          rdata_q;
  logic                rvalid_q, wreq_q, done_q;
  logic                addr_nack_q, data_nack_q;
  logic [CNT_W-1:0]    nack_idx_q;

  logic       tick;
  logic [1:0] phase;
  logic       adv, samp, set_sda, start_low;
  logic       sda_s;
  logic [7:0] sh_q;
  logic       sh_load, sh_shift;
  logic [7:0] sh_val;
  logic       last_byte, tx_bit, ack_slot;

  // optional input synchronizer
  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign sda_s = sda_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2+1-1:0], sda_i} >> 0;
      end
      assign sda_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  i2c_qtr_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q != ST_IDLE),
    .div_i  (div_q),
    .tick_o (tick),
    .phase_o(phase)
  );

  assign adv       = tick && (phase == 2'd3);
  assign samp      = tick && (phase == 2'd2);
  assign set_sda   = tick && (phase == 2'd0);
  assign start_low = tick && (phase == 2'd1);
  assign ack_slot  = (bit_cnt_q == ACK_SLOT);
  assign last_byte = (byte_idx_q == len_q - CNT_W'(1));

  always_comb begin
    if (ack_slot)              tx_bit = (seg_q == SEG_RD) ? last_byte : 1'b1;
    else if (seg_q == SEG_RD)  tx_bit = 1'b1;
    else                       tx_bit = sh_q[7];
  end

  // next-byte load decision at the end of a ninth clock
  logic next_wr;
  always_comb begin
    next_wr = 1'b0;
    if (adv && (state_q == ST_BITS) && ack_slot) begin
      if (seg_q == SEG_ADDR) next_wr = !ack_q && (len_q != '0) && !rd_q;
      if (seg_q == SEG_WR)   next_wr = !ack_q && !last_byte;
    end
  end

  logic go_ok;
  assign go_ok    = go_i && (state_q == ST_IDLE);
  assign sh_load  = go_ok || next_wr;
  assign sh_val   = go_ok ? {addr_i, rd_i} : wdata_i;
  assign sh_shift = (state_q == ST_BITS) && !ack_slot &&
                    (((seg_q != SEG_RD) && adv) || ((seg_q == SEG_RD) && samp));

  i2c_byte_shift #(.W(8)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sh_load),
    .load_val_i(sh_val),
    .shift_i   (sh_shift),
    .bit_i     (sda_s),
    .q_o       (sh_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      seg_q       <= SEG_ADDR;
      bit_cnt_q   <= '0;
      byte_idx_q  <= '0;
      len_q       <= '0;
      div_q       <= '0;
      rd_q        <= 1'b0;
      ack_q       <= 1'b1;
      sda_oe_q    <= 1'b0;
      rdata_q     <= '0;
      rvalid_q    <= 1'b0;
      wreq_q      <= 1'b0;
      done_q      <= 1'b0;
      addr_nack_q <= 1'b0;
      data_nack_q <= 1'b0;
      nack_idx_q  <= '0;
    end else begin
      rvalid_q <= 1'b0;
      wreq_q   <= next_wr;
      done_q   <= 1'b0;

      if (samp && (state_q == ST_BITS) && ack_slot) ack_q <= sda_s;

      // SDA moves only inside the SCL-low window, or for START/STOP
      if (set_sda && (state_q == ST_BITS)) sda_oe_q <= !tx_bit;
      if (set_sda && (state_q == ST_STOP)) sda_oe_q <= 1'b1;
      if (start_low && (state_q == ST_START)) sda_oe_q <= 1'b1;

      unique case (state_q)
        ST_IDLE: begin
          if (go_i) begin
            state_q     <= ST_START;
            rd_q        <= rd_i;
            len_q       <= len_i;
            div_q       <= div_i;
            byte_idx_q  <= '0;
            addr_nack_q <= 1'b0;
            data_nack_q <= 1'b0;
            nack_idx_q  <= '0;
          end
        end
        ST_START: begin
          if (adv) begin
            state_q   <= ST_BITS;
            seg_q     <= SEG_ADDR;
            bit_cnt_q <= '0;
          end
        end
        ST_BITS: begin
          if (adv) begin
            if (!ack_slot) begin
              bit_cnt_q <= bit_cnt_q + BITCNT_W'(1);
            end else begin
              bit_cnt_q <= '0;
              unique case (seg_q)
                SEG_ADDR: begin
                  if (ack_q) begin
                    addr_nack_q <= 1'b1;
                    state_q     <= ST_STOP;
                  end else if (len_q == '0) begin
                    state_q <= ST_STOP;
                  end else begin
                    byte_idx_q <= '0;
                    seg_q      <= rd_q ? SEG_RD : SEG_WR;
                  end
                end
                SEG_WR: begin
                  if (ack_q) begin
                    data_nack_q <= 1'b1;
                    nack_idx_q  <= byte_idx_q;
                    state_q     <= ST_STOP;
                  end else if (last_byte) begin
                    state_q <= ST_STOP;
                  end else begin
                    byte_idx_q <= byte_idx_q + CNT_W'(1);
                  end
                end
                default: begin
                  rdata_q  <= sh_q;
                  rvalid_q <= 1'b1;
                  if (last_byte) state_q <= ST_STOP;
                  else           byte_idx_q <= byte_idx_q + CNT_W'(1);
                end
              endcase
            end
          end
        end
        default: begin
          if (adv) begin
            state_q  <= ST_IDLE;
            sda_oe_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      endcase
    end
  end

  assign scl_oe_o    = ((state_q == ST_BITS) || (state_q == ST_STOP)) && !phase[1];
  assign sda_oe_o    = sda_oe_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign wreq_o      = wreq_q;
  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;
  assign addr_nack_o = addr_nack_q;
  assign data_nack_o = data_nack_q;
  assign nack_idx_o  = nack_idx_q;

  p_bus_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_oe_o && !sda_oe_o && !wreq_o && !rvalid_o));

  p_start_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START) |-> !scl_oe_o);

  p_sda_not_with_scl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $stable(scl_oe_o));

  p_sda_low_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !scl_oe_o) |-> ((state_q == ST_START) || (state_q == ST_IDLE)));

  p_wreq_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wreq_o |-> (!rd_q && busy_o));

  p_rvalid_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> rd_q);

  p_addr_nack_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_nack_o && busy_o) |-> ((state_q == ST_STOP) && !wreq_o && !rvalid_o));

  p_data_nack_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_nack_o && busy_o) |-> (state_q == ST_STOP));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_go_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && go_i) |=> ($stable(rd_q) && $stable(len_q)));
endmodule

// File: tb/tb_i2c_master_ctrl.sv
module tb_i2c_master_ctrl;
  localparam int DIV_W = 16;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic             go = 1'b0;
  logic [6:0]       addr = '0;
  logic             rd = 1'b0;
  logic [CNT_W-1:0] len = '0;
  logic [7:0]       wdata = '0;
  logic             wreq, rvalid, busy, done, addr_nack, data_nack;
  logic [7:0]       rdata;
  logic [CNT_W-1:0] nack_idx;
  logic             scl_oe, sda_oe, sda_in;
  logic             slave_low = 1'b0;

  assign sda_in = !(sda_oe || slave_low);

  always #4 clk = ~clk;

  i2c_master_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .go_i(go), .addr_i(addr),
    .rd_i(rd), .len_i(len), .wdata_i(wdata), .wreq_o(wreq), .rdata_o(rdata),
    .rvalid_o(rvalid), .busy_o(busy), .done_o(done), .addr_nack_o(addr_nack),
    .data_nack_o(data_nack), .nack_idx_o(nack_idx), .scl_oe_o(scl_oe),
    .sda_oe_o(sda_oe), .sda_i(sda_in)
  );

  typedef struct packed {
    logic       scl;
    logic       sda;
    logic       slv;
    logic       wreq;
    logic       rvalid;
    logic       done;
    logic       busy;
    logic [3:0] tag;
  } exp_t;

  exp_t       sched[$];
  logic [7:0] rexp[$];
  logic [7:0] wb [0:7];
  logic [7:0] rb [0:7];
  int         checks = 0;
  int         fails = 0;
  int         qlen = 1;
  logic       prev_sda = 1'b0;
  logic       pend_w = 1'b0;
  logic       pend_r = 1'b0;
  bit         finished = 1'b0;

  function automatic string tname(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic chk(input int tag, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tname(tag), what, act, expv);
    end
  endtask

  task automatic push_n(input logic scl, input logic sda, input logic slv,
                        input int tag, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.scl = scl; e.sda = sda; e.slv = slv; e.done = 1'b0; e.busy = 1'b1;
      e.tag = 4'(tag);
      e.wreq = pend_w; e.rvalid = pend_r;
      pend_w = 1'b0; pend_r = 1'b0;
      sched.push_back(e);
    end
  endtask

  // one bus bit: bus value b, target pulls low when slv
  task automatic push_bit(input logic b, input logic slv, input int tag);
    push_n(1'b1, prev_sda, slv, tag, qlen);
    push_n(1'b1, !b, slv, tag, qlen);
    push_n(1'b0, !b, slv, tag, 2 * qlen);
    prev_sda = !b;
  endtask

  // nack_at: -1 all acked, 0 address refused, k+1 write byte k refused
  task automatic build(input logic [6:0] a, input logic r, input int n,
                       input int d, input int nack_at);
    logic [7:0] ab;
    int stop_tag;
    qlen = d + 1;
    prev_sda = 1'b0;
    stop_tag = (n == 0) ? 11 : 10;
    push_n(1'b0, 1'b0, 1'b0, 2, 2 * qlen);
    push_n(1'b0, 1'b1, 1'b0, 2, 2 * qlen);
    prev_sda = 1'b1;
    ab = {a, r};
    for (int i = 7; i >= 0; i--) push_bit(ab[i], 1'b0, 4);
    push_bit(1'b1, nack_at != 0, (nack_at == 0) ? 8 : 5);
    if (nack_at != 0) begin
      for (int k = 0; k < n; k++) begin
        if (!r) begin
          bit nk;
          nk = (nack_at == k + 1);
          pend_w = 1'b1;
          for (int i = 7; i >= 0; i--) push_bit(wb[k][i], 1'b0, 6);
          push_bit(1'b1, !nk, nk ? 9 : 6);
          if (nk) break;
        end else begin
          for (int i = 7; i >= 0; i--) push_bit(1'b1, !rb[k][i], 7);
          push_bit(k == n - 1, 1'b0, 7);
          pend_r = 1'b1;
          rexp.push_back(rb[k]);
        end
      end
    end
    push_n(1'b1, prev_sda, 1'b0, stop_tag, qlen);
    push_n(1'b1, 1'b1, 1'b0, stop_tag, qlen);
    push_n(1'b0, 1'b1, 1'b0, stop_tag, 2 * qlen);
    begin
      exp_t e;
      e = '0;
      e.done = 1'b1;
      e.tag = 4'(10);
      sched.push_back(e);
    end
  endtask

  task automatic run(input logic [6:0] a, input logic r, input int n, input int d,
                     input int nack_at, input int busy_go_at);
    int j, widx, rseen;
    build(a, r, n, d, nack_at);
    widx = 0; rseen = 0;
    @(negedge clk);
    addr = a; rd = r; len = CNT_W'(n); div = DIV_W'(d); wdata = wb[0]; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    j = 0;
    while (sched.size() > 0) begin
      exp_t e;
      e = sched.pop_front();
      chk(int'(e.tag), {scl_oe, sda_oe, busy, done, wreq, rvalid},
          {e.scl, e.sda, e.busy, e.done, e.wreq, e.rvalid}, "pins/strobes");
      if (rvalid && e.rvalid && rexp.size() > 0) begin
        chk(7, rdata, rexp.pop_front(), "read byte");
        rseen++;
      end
      if (wreq) begin
        widx++;
        wdata = wb[widx & 7];
      end
      slave_low = e.slv;
      if (j == busy_go_at) begin
        go = 1'b1; addr = 7'h7F; rd = !r; len = CNT_W'(7);
      end else begin
        go = 1'b0;
      end
      j++;
      @(negedge clk);
    end
    slave_low = 1'b0;
    go = 1'b0;
    if (busy_go_at >= 0) chk(12, rseen, r ? n : 0, "bytes delivered after ignored go");
    for (int i = 0; i < 3; i++) begin
      chk(1, {scl_oe, sda_oe, busy, done}, 4'b0000, "idle bus");
      @(negedge clk);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      wb[i] = 8'(8'h3C + 8'(i * 37));
      rb[i] = 8'(8'hA5 ^ 8'(i * 29));
    end
    rb[1] = 8'h00;
    rb[2] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(1, {scl_oe, sda_oe, busy, done, wreq, rvalid}, 6'b0, "reset state");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, {scl_oe, sda_oe, busy, done, wreq, rvalid}, 6'b0, "after reset");

    // two-byte write, all acknowledged
    run(7'h5A, 1'b0, 2, 1, -1, -1);
    chk(8, addr_nack, 0, "no addr nack on write");
    chk(9, data_nack, 0, "no data nack on write");

    // three-byte read, go pulsed mid-transfer
    run(7'h21, 1'b1, 3, 2, -1, 150);
    chk(7, addr_nack, 0, "read addr acked");

    // address refused
    run(7'h33, 1'b0, 2, 0, 0, -1);
    chk(8, addr_nack, 1, "addr nack flag");
    chk(8, data_nack, 0, "no data nack after addr nack");

    // write refused at byte index 1
    run(7'h0F, 1'b0, 3, 1, 2, -1);
    chk(9, data_nack, 1, "data nack flag");
    chk(9, nack_idx, 1, "nack index");
    chk(9, addr_nack, 0, "addr acked before data nack");

    // address only
    run(7'h44, 1'b1, 0, 3, -1, -1);
    chk(11, {addr_nack, data_nack}, 0, "address-only flags cleared");

    // single-byte read at fastest divider, and write with go during busy
    run(7'h7E, 1'b1, 1, 0, -1, -1);
    run(7'h12, 1'b0, 1, 0, -1, 40);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule